// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block picks the two operand values that the decode stage of a five-stage in-order pipeline hands to execute. For each operand it compares the decode source register ID with the destination IDs still held by younger-than-register-file producers: the ALU result just computed in execute, the ALU result and loaded value held in the memory stage, and the ALU result and loaded value held in write-back. When one or more of these match, it forwards the value from the stage closest to decode, so operands reflect serial program order. When nothing matches, the register-file read data passes through.

Operand A carries one extra rule. When the instruction in decode is a call or a jump, A carries the incremented PC and no forwarding applies. Operand B never takes this path. The execute-stage destination it receives is the one left after condition evaluation, so a conditional move that fails presents the "no register" ID and forwards nothing. A loaded value reaches the selector only through the memory and write-back stages. The block is purely combinational. Stall detection and the register file sit outside it.

Top module: `operand_bypass_sel`

## Requirements
- R1: When `dec_icode` is 4'h8 (call) or 4'h7 (jump), `op_a` equals `dec_next_pc` whatever the source and destination IDs are.
- R2: When a source ID equals `ex_dst_id`, that operand is `ex_alu_val`. This source ranks above every other bypass source and is overridden only by R1 on operand A.
- R3: When a source ID matches both `mem_dst_load_id` and `mem_dst_alu_id`, the operand is `mem_load_val`. A match on the ALU destination alone gives `mem_alu_val`.
- R4: A match in the memory stage wins over any match in write-back.
- R5: When a source ID matches both `wb_dst_load_id` and `wb_dst_alu_id`, the operand is `wb_load_val`. A match on the ALU destination alone gives `wb_alu_val`.
- R6: When no destination matches, `op_a` equals `rf_data_a` and `op_b` equals `rf_data_b`.
- R7: ID 4'hF means "no register". A source of 4'hF never matches, and a destination of 4'hF (including a failed conditional move in execute) is never forwarded.
- R8: Operand B follows the same order without the PC override, so a call or jump in decode leaves `op_b` to forwarding.
- R9: The two operands are selected independently, each from its own source ID, so they may come from different stages in the same cycle.
- R10: When the same register is written by the instructions in execute, memory and write-back at once, the execute value, from the youngest producer, is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_icode | input | 4 | Instruction code in decode |
| dec_next_pc | input | 64 | Incremented PC of the decode instruction |
| src_a_id | input | 4 | Source register ID for operand A |
| src_b_id | input | 4 | Source register ID for operand B |
| rf_data_a | input | 64 | Register-file read data for A |
| rf_data_b | input | 64 | Register-file read data for B |
| ex_dst_id | input | 4 | Execute ALU destination after condition evaluation |
| ex_alu_val | input | 64 | ALU result computed in execute |
| mem_dst_alu_id | input | 4 | Memory-stage ALU destination |
| mem_dst_load_id | input | 4 | Memory-stage load destination |
| mem_alu_val | input | 64 | Memory-stage ALU result |
| mem_load_val | input | 64 | Value read from data memory |
| wb_dst_alu_id | input | 4 | Write-back ALU destination |
| wb_dst_load_id | input | 4 | Write-back load destination |
| wb_alu_val | input | 64 | Write-back ALU result |
| wb_load_val | input | 64 | Write-back loaded value |
| op_a | output | 64 | Selected operand A |
| op_b | output | 64 | Selected operand B |

## Verification
The embedded assertions check the following on every evaluation:
- the PC override on A;
- that an execute match outranks everything below it;
- that the "no register" ID never produces a hit;
- that an operand with no hits falls back to register data.

The bench scenarios show the full ranking:
- the load-versus-ALU tie inside the memory stage and inside write-back;
- memory outranking write-back;
- a failed conditional move suppressing the execute path;
- the two operands resolving from different stages in the same cycle.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
   // Bypass source slots; a lower index is closer to decode and wins.
   typedef enum int {
      SRC_EX_ALU   = 0,
      SRC_MEM_LOAD = 1,
      SRC_MEM_ALU  = 2,
      SRC_WB_LOAD  = 3,
      SRC_WB_ALU   = 4
   } fwd_src_e;

   localparam int FWD_SOURCES = 5;
endpackage

// File: rtl/opfwd_match.sv
module opfwd_match #(
   parameter int ID_W = 4
) (
   input  logic [ID_W-1:0] src_id,
   input  logic [ID_W-1:0] dst_id,
   output logic            hit
);
   localparam logic [ID_W-1:0] NO_REG = {ID_W{1'b1}};

   assign hit = (src_id != NO_REG) && (src_id == dst_id);

   always_comb begin
      if (dst_id == NO_REG)
         assert_idle_dst_no_hit_R7: assert (!hit);
   end
endmodule

// File: rtl/opfwd_prio_mux.sv
module opfwd_prio_mux #(
   parameter int WIDTH = 64,
   parameter int N_SRC = 5
) (
   input  logic [N_SRC-1:0]            hits,
   input  logic [N_SRC-1:0][WIDTH-1:0] vals,
   input  logic [WIDTH-1:0]            fallback,
   output logic [WIDTH-1:0]            sel_val
);
   // Scan from oldest to youngest so the lowest matching index is written last.
   always_comb begin
      sel_val = fallback;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (hits[i]) sel_val = vals[i];
      end
   end

   always_comb begin
      if (hits == '0)
         assert_no_hit_fallback_R6: assert (sel_val == fallback);
      if (hits[0])
         assert_earliest_wins_R2: assert (sel_val == vals[0]);
   end
endmodule

// File: rtl/opfwd_lane.sv
module opfwd_lane #(
   parameter int WIDTH   = 64,
   parameter int ID_W    = 4,
   parameter int N_SRC   = 5,
   parameter bit HAS_OVR = 1'b0
) (
   input  logic [ID_W-1:0]             src_id,
   input  logic [N_SRC-1:0][ID_W-1:0]  dst_ids,
   input  logic [N_SRC-1:0][WIDTH-1:0] src_vals,
   input  logic [WIDTH-1:0]            rf_val,
   input  logic                        ovr_req,
   input  logic [WIDTH-1:0]            ovr_val,
   output logic [WIDTH-1:0]            operand
);
   localparam logic [ID_W-1:0] NO_REG = {ID_W{1'b1}};

   logic [N_SRC-1:0] hits;
   logic [WIDTH-1:0] fwd_val;

   for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
      opfwd_match #(.ID_W(ID_W)) u_match (
         .src_id (src_id),
         .dst_id (dst_ids[i]),
         .hit    (hits[i])
      );
   end

   opfwd_prio_mux #(.WIDTH(WIDTH), .N_SRC(N_SRC)) u_mux (
      .hits     (hits),
      .vals     (src_vals),
      .fallback (rf_val),
      .sel_val  (fwd_val)
   );

   if (HAS_OVR) begin : g_ovr
      assign operand = ovr_req ? ovr_val : fwd_val;
   end else begin : g_plain
      logic unused_ovr;
      assign unused_ovr = ^{ovr_req, ovr_val};
      assign operand    = fwd_val;
   end

   always_comb begin
      if (src_id == NO_REG && !(HAS_OVR && ovr_req))
         assert_idle_src_rf_R7: assert (operand == rf_val);
   end
endmodule

// File: rtl/operand_bypass_sel.sv
module operand_bypass_sel #(
   parameter int          WIDTH     = 64,
   parameter int          ID_W      = 4,
   parameter logic [3:0]  CALL_CODE = 4'h8,
   parameter logic [3:0]  JUMP_CODE = 4'h7
) (
   input  logic [3:0]       dec_icode,
   input  logic [WIDTH-1:0] dec_next_pc,
   input  logic [ID_W-1:0]  src_a_id,
   input  logic [ID_W-1:0]  src_b_id,
   input  logic [WIDTH-1:0] rf_data_a,
   input  logic [WIDTH-1:0] rf_data_b,
   input  logic [ID_W-1:0]  ex_dst_id,
   input  logic [WIDTH-1:0] ex_alu_val,
   input  logic [ID_W-1:0]  mem_dst_alu_id,
   input  logic [ID_W-1:0]  mem_dst_load_id,
   input  logic [WIDTH-1:0] mem_alu_val,
   input  logic [WIDTH-1:0] mem_load_val,
   input  logic [ID_W-1:0]  wb_dst_alu_id,
   input  logic [ID_W-1:0]  wb_dst_load_id,
   input  logic [WIDTH-1:0] wb_alu_val,
   input  logic [WIDTH-1:0] wb_load_val,
   output logic [WIDTH-1:0] op_a,
   output logic [WIDTH-1:0] op_b
);
   import opfwd_pkg::*;

   localparam int              N_SRC  = FWD_SOURCES;
   localparam logic [ID_W-1:0] NO_REG = {ID_W{1'b1}};

   if (WIDTH < 1) begin : g_bad_width
      $error("operand_bypass_sel: WIDTH must be at least 1");
   end
   if (ID_W < 2) begin : g_bad_idw
      $error("operand_bypass_sel: ID_W must be at least 2");
   end

   logic [N_SRC-1:0][ID_W-1:0]  dst_ids;
   logic [N_SRC-1:0][WIDTH-1:0] dst_vals;
   logic                        pc_ovr;

   always_comb begin
      dst_ids[SRC_EX_ALU]   = ex_dst_id;
      dst_ids[SRC_MEM_LOAD] = mem_dst_load_id;
      dst_ids[SRC_MEM_ALU]  = mem_dst_alu_id;
      dst_ids[SRC_WB_LOAD]  = wb_dst_load_id;
      dst_ids[SRC_WB_ALU]   = wb_dst_alu_id;
      dst_vals[SRC_EX_ALU]   = ex_alu_val;
      dst_vals[SRC_MEM_LOAD] = mem_load_val;
      dst_vals[SRC_MEM_ALU]  = mem_alu_val;
      dst_vals[SRC_WB_LOAD]  = wb_load_val;
      dst_vals[SRC_WB_ALU]   = wb_alu_val;
   end

   assign pc_ovr = (dec_icode == CALL_CODE) || (dec_icode == JUMP_CODE);

   opfwd_lane #(.WIDTH(WIDTH), .ID_W(ID_W), .N_SRC(N_SRC), .HAS_OVR(1'b1)) u_lane_a (
      .src_id   (src_a_id),
      .dst_ids  (dst_ids),
      .src_vals (dst_vals),
      .rf_val   (rf_data_a),
      .ovr_req  (pc_ovr),
      .ovr_val  (dec_next_pc),
      .operand  (op_a)
   );

   opfwd_lane #(.WIDTH(WIDTH), .ID_W(ID_W), .N_SRC(N_SRC), .HAS_OVR(1'b0)) u_lane_b (
      .src_id   (src_b_id),
      .dst_ids  (dst_ids),
      .src_vals (dst_vals),
      .rf_val   (rf_data_b),
      .ovr_req  (1'b0),
      .ovr_val  ({WIDTH{1'b0}}),
      .operand  (op_b)
   );

   always_comb begin
      if (dec_icode == CALL_CODE || dec_icode == JUMP_CODE)
         assert_pc_override_R1: assert (op_a == dec_next_pc);
      if (src_b_id != NO_REG && src_b_id == ex_dst_id)
         assert_b_ex_first_R8: assert (op_b == ex_alu_val);
      if (!pc_ovr && src_a_id != NO_REG && src_a_id == ex_dst_id)
         assert_a_youngest_R10: assert (op_a == ex_alu_val);
   end
endmodule

// File: tb/tb_operand_bypass_sel.sv
module tb_operand_bypass_sel;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 5000;
   localparam int NV         = 14;

   // Expected-source codes.
   localparam logic [2:0] S_PC = 3'd0, S_EX = 3'd1, S_MLD = 3'd2, S_MAL = 3'd3,
                          S_WLD = 3'd4, S_WAL = 3'd5, S_RF = 3'd6;

   localparam logic [63:0] V_PC  = 64'h0000_0000_0000_1000;
   localparam logic [63:0] V_EX  = 64'h1111_0000_0000_00E1;
   localparam logic [63:0] V_MLD = 64'h2222_0000_0000_00D2;
   localparam logic [63:0] V_MAL = 64'h3333_0000_0000_00A3;
   localparam logic [63:0] V_WLD = 64'h4444_0000_0000_00D4;
   localparam logic [63:0] V_WAL = 64'h5555_0000_0000_00A5;
   localparam logic [63:0] V_RFA = 64'h6666_0000_0000_00FA;
   localparam logic [63:0] V_RFB = 64'h7777_0000_0000_00FB;

   typedef struct packed {
      logic [3:0] icode, sa, sb, exd, mdl, mda, wdl, wda;
      logic [2:0] ea, eb;
      logic [3:0] req;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{4'h6, 4'h2, 4'h3, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, S_RF,  S_RF,  4'd6},  // R6
      '{4'h6, 4'h2, 4'h3, 4'h2, 4'hF, 4'hF, 4'hF, 4'hF, S_EX,  S_RF,  4'd2},  // R2
      '{4'h6, 4'h4, 4'h4, 4'hF, 4'h4, 4'h4, 4'hF, 4'hF, S_MLD, S_MLD, 4'd3},  // R3
      '{4'h6, 4'h4, 4'h5, 4'hF, 4'hF, 4'h4, 4'hF, 4'hF, S_MAL, S_RF,  4'd3},  // R3
      '{4'h6, 4'h1, 4'h1, 4'hF, 4'hF, 4'h1, 4'h1, 4'h1, S_MAL, S_MAL, 4'd4},  // R4
      '{4'h6, 4'h6, 4'h6, 4'hF, 4'hF, 4'hF, 4'h6, 4'h6, S_WLD, S_WLD, 4'd5},  // R5
      '{4'h6, 4'h6, 4'h7, 4'hF, 4'hF, 4'hF, 4'h7, 4'h6, S_WAL, S_WLD, 4'd5},  // R5
      '{4'h8, 4'h2, 4'h2, 4'h2, 4'hF, 4'hF, 4'hF, 4'hF, S_PC,  S_EX,  4'd1},  // R1
      '{4'h7, 4'hF, 4'h3, 4'hF, 4'hF, 4'hF, 4'hF, 4'h3, S_PC,  S_WAL, 4'd1},  // R1
      '{4'h6, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, S_RF,  S_RF,  4'd7},  // R7
      '{4'h2, 4'h2, 4'hF, 4'hF, 4'hF, 4'h2, 4'hF, 4'hF, S_MAL, S_RF,  4'd7},  // R7 failed cmove
      '{4'h6, 4'h0, 4'h0, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0, S_EX,  S_EX,  4'd10}, // R10
      '{4'h6, 4'h2, 4'h3, 4'h3, 4'h2, 4'hF, 4'hF, 4'hF, S_MLD, S_EX,  4'd9},  // R9
      '{4'h8, 4'h5, 4'h5, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, S_PC,  S_RF,  4'd8}   // R8
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [3:0]  dec_icode;
   logic [63:0] dec_next_pc, rf_data_a, rf_data_b;
   logic [3:0]  src_a_id, src_b_id, ex_dst_id;
   logic [3:0]  mem_dst_alu_id, mem_dst_load_id, wb_dst_alu_id, wb_dst_load_id;
   logic [63:0] ex_alu_val, mem_alu_val, mem_load_val, wb_alu_val, wb_load_val;
   logic [63:0] op_a, op_b;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   operand_bypass_sel dut (
      .dec_icode(dec_icode), .dec_next_pc(dec_next_pc),
      .src_a_id(src_a_id), .src_b_id(src_b_id),
      .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
      .ex_dst_id(ex_dst_id), .ex_alu_val(ex_alu_val),
      .mem_dst_alu_id(mem_dst_alu_id), .mem_dst_load_id(mem_dst_load_id),
      .mem_alu_val(mem_alu_val), .mem_load_val(mem_load_val),
      .wb_dst_alu_id(wb_dst_alu_id), .wb_dst_load_id(wb_dst_load_id),
      .wb_alu_val(wb_alu_val), .wb_load_val(wb_load_val),
      .op_a(op_a), .op_b(op_b)
   );

   function automatic string tag(input logic [3:0] r);
      case (r)
         4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
         4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
         4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [63:0] pick(input logic [2:0] s, input logic [63:0] rf);
      case (s)
         S_PC:  return V_PC;
         S_EX:  return V_EX;
         S_MLD: return V_MLD;
         S_MAL: return V_MAL;
         S_WLD: return V_WLD;
         S_WAL: return V_WAL;
         default: return rf;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      dec_icode = v.icode;  src_a_id = v.sa;  src_b_id = v.sb;
      ex_dst_id = v.exd;    mem_dst_load_id = v.mdl;  mem_dst_alu_id = v.mda;
      wb_dst_load_id = v.wdl;  wb_dst_alu_id = v.wda;
      #1;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= WD_LIMIT) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WD_LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      dec_next_pc = V_PC;   rf_data_a = V_RFA;  rf_data_b = V_RFB;
      ex_alu_val = V_EX;    mem_load_val = V_MLD; mem_alu_val = V_MAL;
      wb_load_val = V_WLD;  wb_alu_val = V_WAL;
      dec_icode = 4'h0; src_a_id = 4'hF; src_b_id = 4'hF;
      ex_dst_id = 4'hF; mem_dst_load_id = 4'hF; mem_dst_alu_id = 4'hF;
      wb_dst_load_id = 4'hF; wb_dst_alu_id = 4'hF;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;

      // Idle state: every ID is "no register", so register data passes (R6).
      @(negedge clk); #1;
      check("R6", "idle op_a", op_a, V_RFA);
      check("R6", "idle op_b", op_b, V_RFB);

      // Vector table.
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         check(tag(VECS[i].req), $sformatf("vec %0d op_a", i), op_a, pick(VECS[i].ea, V_RFA));
         check(tag(VECS[i].req), $sformatf("vec %0d op_b", i), op_b, pick(VECS[i].eb, V_RFB));
      end

      // R7: a source of 0xF against destinations of 0xF everywhere does not forward,
      // even with register-file data changed.
      @(negedge clk);
      dec_icode = 4'h6; src_a_id = 4'hF; src_b_id = 4'hF;
      ex_dst_id = 4'hF; mem_dst_load_id = 4'hF; mem_dst_alu_id = 4'hF;
      wb_dst_load_id = 4'hF; wb_dst_alu_id = 4'hF;
      rf_data_a = 64'hDEAD_BEEF_0000_0001; rf_data_b = 64'hDEAD_BEEF_0000_0002;
      #1;
      check("R7", "all-idle op_a", op_a, 64'hDEAD_BEEF_0000_0001);
      check("R7", "all-idle op_b", op_b, 64'hDEAD_BEEF_0000_0002);

      // R1: a different PC value follows through on a jump despite an execute match.
      @(negedge clk);
      dec_icode = 4'h7; src_a_id = 4'h9; ex_dst_id = 4'h9;
      dec_next_pc = 64'h0000_0000_0000_0ABC;
      #1;
      check("R1", "jump op_a", op_a, 64'h0000_0000_0000_0ABC);

      // R8: the icode leaves op_b to forwarding; B matches write-back load only.
      src_b_id = 4'hC; wb_dst_load_id = 4'hC;
      #1;
      check("R8", "call/jump op_b", op_b, V_WLD);

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule